// File: doc/BRIEF.md
# Terminated String Copy Engine

This block copies a run of bytes, one at a time, from a source address to a destination address. It stops once it has written a chosen terminator byte, or once it has moved a fixed number of bytes in a single call. A caller supplies both start addresses, a terminator word and an address-mode flag, then pulses `start`. The engine reads each byte through a byte read port and writes it through a byte write port. Each port uses a request held until the memory answers.

When it stops, the engine gives a one-cycle `done` pulse together with a 2-bit condition code and two returned addresses. Code 1 means the terminator was found and copied. The returned destination then points at the terminator just written, and the returned source is the start source, not advanced. Code 3 means the per-call byte cap was reached without a terminator. Both returned addresses are then advanced by the cap, so software can call again with them and continue the copy.

Top module: `term_copy_engine`

## Requirements
- R1: Only bits [7:0] of `term_in` form the terminator byte. A source byte equal to any higher byte of `term_in` is copied like ordinary data and does not stop the copy.
- R2: With `wide_mode` = 0, the destination and source start addresses are cut to their low NARROW_W bits before use. Every address on `rd_addr`, `wr_addr`, `dst_out` and `src_out` then has all bits at and above NARROW_W clear.
- R3: For offsets k = 0, 1, 2, … in increasing order, the byte read at source+k is written unchanged to destination+k. `wr_addr` and `wr_data` stay stable while `wr_req` waits for `wr_ack`.
- R4: The terminator byte is itself written to the destination as the last write of the call.
- R5: When the copied byte equals the terminator at offset k, `cc` = 1 (2'b01), `dst_out` = destination+k and `src_out` = the masked start source.
- R6: After CAP bytes are copied with no terminator, `cc` = 3 (2'b11), exactly CAP writes have been made, and `dst_out` and `src_out` are both the start addresses plus CAP.
- R7: A write is requested only after the read data for that offset has been accepted (`rd_req` and `rd_valid` high at one edge). The next read is requested only after `wr_ack`. `rd_req` and `wr_req` are never high together.
- R8: Address sums wrap modulo 2^NARROW_W when `wide_mode` = 0, and modulo 2^ADDR_W when `wide_mode` = 1.
- R9: `done` is high for exactly one cycle per call. `cc`, `dst_out` and `src_out` hold their values until the next call ends. A `start` pulse while a call is in progress is ignored.
- R10: A synchronous reset returns the engine to idle: `rd_req`, `wr_req` and `done` go low, and the results clear to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a call when the engine is idle |
| wide_mode | input | 1 | 1: full-width addressing; 0: NARROW_W-bit addressing |
| dst_addr | input | ADDR_W | Destination start address |
| src_addr | input | ADDR_W | Source start address |
| term_in | input | TERM_W | Terminator word; only bits [7:0] are used |
| rd_req | output | 1 | Source read request, held until `rd_valid` |
| rd_addr | output | ADDR_W | Source read address |
| rd_valid | input | 1 | Read data valid; completes the pending read |
| rd_data | input | 8 | Source read data |
| wr_req | output | 1 | Destination write request, held until `wr_ack` |
| wr_addr | output | ADDR_W | Destination write address |
| wr_data | output | 8 | Destination write data |
| wr_ack | input | 1 | Write accepted |
| done | output | 1 | One-cycle end-of-call pulse |
| cc | output | 2 | Condition code: 1 terminator copied, 3 cap reached |
| dst_out | output | ADDR_W | Returned destination address |
| src_out | output | ADDR_W | Returned source address |

## Verification
The bench builds the engine with ADDR_W = 12, NARROW_W = 8, CAP = 16 and TERM_W = 16. With these values the whole space of stop points can be swept: the terminator is placed at every offset from 0 to CAP-1, and one more run has no terminator at all. Each of these runs is done in both address modes. The start addresses are chosen so that copies cross the 256-byte and 4096-byte wrap points and carry high bits that narrow mode must strip. The memory model's response latency also varies from run to run, so the read-then-write ordering is tested under stalls.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [1:0] {
    TC_IDLE  = 2'd0,
    TC_READ  = 2'd1,
    TC_WRITE = 2'd2
  } tc_state_e;

  localparam logic [1:0] TC_CC_FOUND   = 2'd1;
  localparam logic [1:0] TC_CC_PARTIAL = 2'd3;
  localparam int         TC_BYTE_W     = 8;
endpackage

// File: rtl/tc_addr_unit.sv
// Address arithmetic for one pointer: current offset and next offset,
// both folded to the active address width.
module tc_addr_unit #(
  parameter int ADDR_W   = 64,
  parameter int NARROW_W = 31,
  parameter int CNT_W    = 14
) (
  input  logic              wide,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  off,
  output logic [ADDR_W-1:0] cur,
  output logic [ADDR_W-1:0] nxt
);
  localparam logic [ADDR_W-1:0] NARROW_MASK = (ADDR_W'(1) << NARROW_W) - ADDR_W'(1);

  function automatic logic [ADDR_W-1:0] fold(input logic w, input logic [ADDR_W-1:0] a);
    return w ? a : (a & NARROW_MASK);
  endfunction

  function automatic logic [ADDR_W-1:0] offset_sum(input logic [ADDR_W-1:0] b,
                                                   input logic [CNT_W-1:0] o,
                                                   input logic extra);
    return b + ADDR_W'(o) + ADDR_W'(extra);
  endfunction

  always_comb begin
    cur = fold(wide, offset_sum(base, off, 1'b0));
    nxt = fold(wide, offset_sum(base, off, 1'b1));
  end
endmodule

// File: rtl/tc_step_counter.sv
// Byte offset within a call; flags the last offset before the cap.
module tc_step_counter #(
  parameter int CAP   = 8192,
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  output logic [CNT_W-1:0] count,
  output logic             last
);
  localparam logic [CNT_W-1:0] LAST_OFF = CNT_W'(CAP - 1);

  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else if (step)    count <= count + CNT_W'(1);
  end

  assign last = (count == LAST_OFF);
endmodule

// File: rtl/tc_ctrl.sv
// Sequencer: idle -> read -> write -> (read | idle).
module tc_ctrl
  import tc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic rd_valid,
  input  logic wr_ack,
  input  logic hit,
  input  logic last,
  output logic rd_req,
  output logic wr_req,
  output logic load,
  output logic rd_fire,
  output logic wr_fire,
  output logic fin_found,
  output logic fin_cap,
  output logic step
);
  tc_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TC_IDLE;
    end else begin
      unique case (state_q)
        TC_IDLE:  if (start)    state_q <= TC_READ;
        TC_READ:  if (rd_valid) state_q <= TC_WRITE;
        TC_WRITE: if (wr_ack)   state_q <= (hit || last) ? TC_IDLE : TC_READ;
        default:                state_q <= TC_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_req    = (state_q == TC_READ);
    wr_req    = (state_q == TC_WRITE);
    load      = (state_q == TC_IDLE) && start;
    rd_fire   = rd_req && rd_valid;
    wr_fire   = wr_req && wr_ack;
    fin_found = wr_fire && hit;
    fin_cap   = wr_fire && !hit && last;
    step      = wr_fire && !hit && !last;
  end
endmodule

// File: rtl/term_copy_engine.sv
module term_copy_engine
  import tc_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int NARROW_W = 31,
  parameter int CAP      = 8192,
  parameter int TERM_W   = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wide_mode,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [TERM_W-1:0] term_in,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [7:0]        rd_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  input  logic              wr_ack,
  output logic              done,
  output logic [1:0]        cc,
  output logic [ADDR_W-1:0] dst_out,
  output logic [ADDR_W-1:0] src_out
);
  localparam int CNT_W = $clog2(CAP + 1);
  localparam int CH_DST = 0;
  localparam int CH_SRC = 1;
  localparam logic [ADDR_W-1:0] NARROW_MASK = (ADDR_W'(1) << NARROW_W) - ADDR_W'(1);

  function automatic logic [ADDR_W-1:0] entry_fold(input logic w, input logic [ADDR_W-1:0] a);
    return w ? a : (a & NARROW_MASK);
  endfunction

  // Upper terminator bits carry no meaning.
  logic unused_term_hi;
  assign unused_term_hi = ^term_in[TERM_W-1:TC_BYTE_W];

  logic [ADDR_W-1:0]    base_q [2];
  logic [ADDR_W-1:0]    cur_a  [2];
  logic [ADDR_W-1:0]    nxt_a  [2];
  logic [ADDR_W-1:0]    res_q  [2];
  logic [TC_BYTE_W-1:0] term_q;
  logic [TC_BYTE_W-1:0] data_q;
  logic                 wide_q;
  logic [1:0]           cc_q;
  logic                 done_q;

  // Named events for the checker.
  logic             load, rd_fire, wr_fire, fin_found, fin_cap, step;
  logic             hit, last, narrow_act;
  logic [CNT_W-1:0] off;

  assign hit        = (data_q == term_q);
  assign narrow_act = !wide_q;

  tc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .rd_valid(rd_valid), .wr_ack(wr_ack),
    .hit(hit), .last(last), .rd_req(rd_req), .wr_req(wr_req), .load(load),
    .rd_fire(rd_fire), .wr_fire(wr_fire), .fin_found(fin_found),
    .fin_cap(fin_cap), .step(step)
  );

  tc_step_counter #(.CAP(CAP), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clear(load), .step(step), .count(off), .last(last)
  );

  for (genvar c = 0; c < 2; c++) begin : g_chan
    tc_addr_unit #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .CNT_W(CNT_W)) u_addr (
      .wide(wide_q), .base(base_q[c]), .off(off), .cur(cur_a[c]), .nxt(nxt_a[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q[CH_DST] <= '0;
      base_q[CH_SRC] <= '0;
      res_q[CH_DST]  <= '0;
      res_q[CH_SRC]  <= '0;
      term_q         <= '0;
      data_q         <= '0;
      wide_q         <= 1'b0;
      cc_q           <= 2'd0;
      done_q         <= 1'b0;
    end else begin
      done_q <= fin_found || fin_cap;
      if (load) begin
        base_q[CH_DST] <= entry_fold(wide_mode, dst_addr);
        base_q[CH_SRC] <= entry_fold(wide_mode, src_addr);
        term_q         <= term_in[TC_BYTE_W-1:0];
        wide_q         <= wide_mode;
      end
      if (rd_fire) data_q <= rd_data;
      if (fin_found) begin
        cc_q          <= TC_CC_FOUND;
        res_q[CH_DST] <= cur_a[CH_DST];
        res_q[CH_SRC] <= base_q[CH_SRC];
      end else if (fin_cap) begin
        cc_q          <= TC_CC_PARTIAL;
        res_q[CH_DST] <= nxt_a[CH_DST];
        res_q[CH_SRC] <= nxt_a[CH_SRC];
      end
    end
  end

  assign rd_addr = cur_a[CH_SRC];
  assign wr_addr = cur_a[CH_DST];
  assign wr_data = data_q;
  assign done    = done_q;
  assign cc      = cc_q;
  assign dst_out = res_q[CH_DST];
  assign src_out = res_q[CH_SRC];
endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
  parameter int ADDR_W   = 64,
  parameter int NARROW_W = 31
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_req,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_req,
  input logic              wr_ack,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              done,
  input logic [1:0]        cc,
  input logic              narrow
);
  AST_NO_DUAL_REQ: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && wr_req)); // R7
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_req) |-> $past(rd_req && rd_valid)); // R7
  AST_RD_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    ($rose(rd_req) && $past(wr_req)) |-> $past(wr_ack)); // R7
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_CC_CODE: assert property (@(posedge clk) disable iff (rst)
    done |-> (cc == 2'd1 || cc == 2'd3)); // R5
  AST_NARROW_RD: assert property (@(posedge clk) disable iff (rst)
    (rd_req && narrow) |-> ((rd_addr >> NARROW_W) == '0)); // R2
  AST_NARROW_WR: assert property (@(posedge clk) disable iff (rst)
    (wr_req && narrow) |-> ((wr_addr >> NARROW_W) == '0)); // R2
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!rd_req && !wr_req && !done)); // R10
endmodule

bind term_copy_engine tc_checker #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_chk (
  .clk(clk), .rst(rst), .rd_req(rd_req), .rd_valid(rd_valid), .rd_addr(rd_addr),
  .wr_req(wr_req), .wr_ack(wr_ack), .wr_addr(wr_addr), .wr_data(wr_data),
  .done(done), .cc(cc), .narrow(narrow_act)
);

// File: tb/sim_term_copy_engine.sv
`timescale 1ns/1ps
module sim_term_copy_engine;
  localparam int AW  = 12;
  localparam int NW  = 8;
  localparam int CP  = 16;
  localparam int TW  = 16;
  localparam logic [7:0] HI_BYTE = 8'hA5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          wide_mode = 1'b0;
  logic [AW-1:0] dst_addr = '0;
  logic [AW-1:0] src_addr = '0;
  logic [TW-1:0] term_in = '0;
  logic          rd_req, wr_req, done;
  logic [AW-1:0] rd_addr, wr_addr, dst_out, src_out;
  logic          rd_valid = 1'b0;
  logic [7:0]    rd_data = '0;
  logic [7:0]    wr_data;
  logic          wr_ack = 1'b0;
  logic [1:0]    cc;

  always #10 clk = ~clk;

  term_copy_engine #(.ADDR_W(AW), .NARROW_W(NW), .CAP(CP), .TERM_W(TW)) u0 (
    .clk(clk), .rst(rst), .start(start), .wide_mode(wide_mode),
    .dst_addr(dst_addr), .src_addr(src_addr), .term_in(term_in),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .done(done), .cc(cc), .dst_out(dst_out), .src_out(src_out)
  );

  int checks = 0;
  int fails  = 0;
  logic [7:0]    mem [4096];
  logic [AW-1:0] wl_addr [64];
  logic [7:0]    wl_data [64];
  int wl_n = 0, rd_n = 0, dual_n = 0, lat = 0, rd_wait = 0, wr_wait = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Memory model: latency lat cycles on both ports, writes are logged.
  initial begin
    forever begin
      @(negedge clk);
      if (rd_req && wr_req) dual_n++;
      if (rd_valid) begin
        rd_valid = 1'b0;
        rd_wait  = lat;
      end else if (rd_req) begin
        if (rd_wait == 0) begin
          rd_valid = 1'b1;
          rd_data  = mem[rd_addr];
          rd_n++;
        end else rd_wait--;
      end
      if (wr_ack) begin
        wr_ack  = 1'b0;
        wr_wait = lat;
      end else if (wr_req) begin
        if (wr_wait == 0) begin
          wr_ack = 1'b1;
          if (wl_n < 64) begin
            wl_addr[wl_n] = wr_addr;
            wl_data[wl_n] = wr_data;
          end
          wl_n++;
        end else wr_wait--;
      end
    end
  end

  initial begin
    #(20 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  function automatic logic [7:0] filler(input int i, input logic [7:0] t);
    logic [7:0] v;
    v = 8'((i * 37 + 11) & 255);
    if (i == 1) v = HI_BYTE;
    if (v == t) v = v ^ 8'h01;
    return v;
  endfunction

  task automatic run(input logic [AW-1:0] d, input logic [AW-1:0] s, input logic [7:0] t,
                     input bit w, input int k, input int l, input bit poke);
    logic [AW-1:0] m, d0, s0, ed, es;
    logic [1:0]    ecc;
    int n, guard;
    m  = w ? {AW{1'b1}} : AW'((1 << NW) - 1);
    d0 = d & m;
    s0 = s & m;
    for (int i = 0; i <= CP + 1; i++)
      mem[(s0 + AW'(i)) & m] = (i == k) ? t : filler(i, t);
    n   = (k < CP) ? k + 1 : CP;
    ecc = (k < CP) ? 2'd1 : 2'd3;
    ed  = (k < CP) ? ((d0 + AW'(k)) & m) : ((d0 + AW'(CP)) & m);
    es  = (k < CP) ? s0 : ((s0 + AW'(CP)) & m);
    @(negedge clk);
    wl_n = 0; rd_n = 0; dual_n = 0; lat = l; rd_wait = l; wr_wait = l;
    dst_addr = d; src_addr = s; term_in = {HI_BYTE, t}; wide_mode = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      dst_addr = 12'h7C0; src_addr = 12'h0C0; term_in = 16'h0000; wide_mode = ~w; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk(done, "R9 done seen", done, 1);
    chk(wl_n == n, (k < CP) ? "R4 write count" : "R6 write count", wl_n, n);
    if (k > 1) chk(wl_n > 2, "R1 high terminator byte ignored", wl_n, n);
    chk(rd_n == wl_n, "R7 reads match writes", rd_n, wl_n);
    chk(dual_n == 0, "R7 no dual request", dual_n, 0);
    for (int i = 0; i < n && i < wl_n && i < 64; i++) begin
      chk(wl_addr[i] == ((d0 + AW'(i)) & m), w ? "R8 write address" : "R2 write address",
          wl_addr[i], (d0 + AW'(i)) & m);
      chk(wl_data[i] == ((i == k) ? t : filler(i, t)), (i == k) ? "R4 terminator data" : "R3 data",
          wl_data[i], (i == k) ? t : filler(i, t));
    end
    chk(cc == ecc, (k < CP) ? "R5 cc" : "R6 cc", cc, ecc);
    chk(dst_out == ed, (k < CP) ? "R5 dst_out" : "R6 dst_out", dst_out, ed);
    chk(src_out == es, (k < CP) ? "R5 src_out" : "R6 src_out", src_out, es);
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
    repeat (2) @(negedge clk);
    chk(cc == ecc && dst_out == ed && src_out == es, "R9 results held", dst_out, ed);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!rd_req && !wr_req && !done, "R10 reset idle", {rd_req, wr_req, done}, 0);
    chk(cc == 2'd0 && dst_out == '0 && src_out == '0, "R10 reset results", dst_out, 0);
    rst = 1'b0;
    @(negedge clk);
    for (int w = 0; w < 2; w++) begin
      for (int k = 0; k <= CP; k++) begin
        logic [7:0] t;
        t = 8'((k * 13 + 1) & 255);
        if (t == HI_BYTE) t = 8'h00;
        if (w == 0) run(12'hF00 | 12'h0FA, 12'h300 | 12'h010, t, 1'b0, k, k % 3, k >= 3);
        else        run(12'h100, 12'hFF8, t, 1'b1, k, k % 3, k >= 3);
      end
    end
    // Swapped roles: destination wraps in narrow mode.
    run(12'hAF9, 12'h520, 8'h00, 1'b0, 10, 1, 1'b0);
    // Reset during a call.
    @(negedge clk);
    lat = 2; rd_wait = 2; wr_wait = 2;
    dst_addr = 12'h040; src_addr = 12'h080; term_in = 16'h0077; wide_mode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!rd_req && !wr_req && !done, "R10 reset mid call", {rd_req, wr_req, done}, 0);
    chk(cc == 2'd0 && dst_out == '0, "R10 results cleared", dst_out, 0);
    rst = 1'b0;
    rd_valid = 1'b0; wr_ack = 1'b0;
    repeat (2) @(negedge clk);
    run(12'h200, 12'h010, 8'h3C, 1'b1, 5, 0, 1'b0);
    summary();
  end
endmodule